// File: doc/BRIEF.md
# Passive-Matrix LCD Scan Controller

This block drives the line and frame scan of a passive-matrix LCD panel. It fetches frame-buffer words from a memory window through a simple request/acknowledge read port. Each word is then sent out as four nibbles on a 4-bit data bus, one shift strobe per nibble. The panel also receives a frame marker, a line-load pulse and an AC-bias (DF) signal.

Configuration arrives as static input ports:
- pixel depth, split-panel flag and panel size in pixels,
- data inversion,
- DF mode and line rate,
- freeze request,
- the word-address window of the frame buffer.

The scan sequencer has five states:
- `ST_IDLE`: quiet, pointer parked at the window start.
- `ST_FETCH`: read request raised.
- `ST_SHIFT`: one nibble per cycle.
- `ST_LOAD`: one-cycle line-load pulse.
- `ST_HALT`: frozen after a frame boundary.

Its transitions are:
- `IDLE->FETCH` when enabled and not frozen.
- `FETCH->SHIFT` on acknowledge.
- `SHIFT->FETCH` after the last nibble of a word that is not the last of the line.
- `SHIFT->LOAD` after the last nibble of the last word.
- `LOAD->FETCH` to start the next line, or a new frame when freeze is clear.
- `LOAD->HALT` at the last line while freeze is set.
- `HALT->IDLE` when freeze clears.
- Any state goes to `IDLE` when the enable drops.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset, dma_req, shift_stb, line_load, frame and df are low and vdat is 0.
- R2: One cycle after vid_en is sampled low, dma_req, shift_stb, line_load, frame, df and vdat are all low, and no request is issued while it stays low. disp_on always equals disp_on_cfg, independent of vid_en.
- R3: Words per line are (width_px/8)*3 when depth is 3 (8-bit colour; codes 0..3 select 1, 2, 4, 8 bits per pixel) and split is 0, and width_px/4 in every other case. Each word yields four shift_stb cycles, and line_load is a single cycle right after the last of them.
- R4: Lines per frame are height_px, or height_px/2 when split is 1.
- R5: frame is high in every active cycle (request, shift or load) of the first line of a frame and low in the active cycles of other lines.
- R6: Nibbles leave most-significant first (bits 15:12, then 11:8, 7:4, 3:0), and vdat is 0 in every cycle without shift_stb.
- R7: With invert set, vdat carries the complement of each nibble.
- R8: dma_req stays high with dma_addr stable until dma_ack. Addresses start at win_start, advance by one word per acknowledge, wrap to win_start on reaching win_end, and restart at win_start on every new frame.
- R9: With df_mode 0, df toggles exactly once per frame, after the last line-load.
- R10: With df_mode 1, df toggles after every df_rate+1 line-loads, counted from enable.
- R11: Setting freeze mid-frame lets that frame finish, then issues no request or strobe until freeze clears. Scanning then restarts at line 0 from win_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_en | input | 1 | Scan enable |
| disp_on_cfg | input | 1 | Panel power control bit |
| invert | input | 1 | Complement data nibbles |
| depth | input | 2 | Pixel depth code |
| split | input | 1 | Split-panel mode |
| width_px | input | PIX_W | Panel width in pixels |
| height_px | input | LINE_W | Panel height in lines |
| df_mode | input | 1 | 0: DF per frame, 1: DF per line count |
| df_rate | input | RATE_W | Lines per DF toggle minus one |
| freeze | input | 1 | Stop at next frame boundary |
| win_start | input | AW | First word address of the buffer |
| win_end | input | AW | Address one past the last word |
| dma_req | output | 1 | Read request |
| dma_addr | output | AW | Read word address |
| dma_ack | input | 1 | Read acknowledge with data |
| dma_rdata | input | DATA_W | Read data |
| frame | output | 1 | First-line marker |
| line_load | output | 1 | End-of-line latch pulse |
| shift_stb | output | 1 | Nibble shift strobe |
| df | output | 1 | AC-bias signal |
| disp_on | output | 1 | Panel power output |
| vdat | output | 4 | Panel data nibble |

## Verification
The hardest situation to reach from the ports is a freeze request that lands in the middle of a frame. The controller must finish that frame, sit silent, and then restart from the window start. The bench waits for a chosen line of the second frame before raising freeze, confirms that the request and strobe counts no longer move, and then releases freeze. An independent address model then checks that the first fetch returns to the window start. Address wrap inside a line is reached with a window shorter than one frame, and the wait-state memory model holds requests open to exercise address stability.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SHIFT,
        ST_LOAD,
        ST_HALT
    } scan_state_t;

    localparam logic [1:0] DEPTH_COLOR8 = 2'd3;
endpackage

// File: rtl/lcd_scan_geom.sv
module lcd_scan_geom
    import lcd_scan_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 10
) (
    input  logic [1:0]        depth,
    input  logic              split,
    input  logic [PIX_W-1:0]  width_px,
    input  logic [LINE_W-1:0] height_px,
    output logic [PIX_W-1:0]  xfer_last,
    output logic [LINE_W-1:0] line_last
);
    logic [PIX_W-1:0]  eighths;
    logic [PIX_W-1:0]  xfers;
    logic [LINE_W-1:0] lines;

    always_comb begin
        eighths = width_px >> 3;
        if (depth == DEPTH_COLOR8 && !split) begin
            xfers = (eighths << 1) + eighths;
        end else begin
            xfers = width_px >> 2;
        end
        lines     = split ? (height_px >> 1) : height_px;
        xfer_last = xfers - PIX_W'(1);
        line_last = lines - LINE_W'(1);
    end
endmodule

// File: rtl/lcd_scan_dma_ptr.sv
module lcd_scan_dma_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic [AW-1:0] win_start,
    input  logic [AW-1:0] win_end,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] incr;

    assign incr = ptr + AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (restart) begin
            ptr <= win_start;
        end else if (step) begin
            ptr <= (incr == win_end) ? win_start : incr;
        end
    end
endmodule

// File: rtl/lcd_scan_df.sv
module lcd_scan_df #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode,
    input  logic [RATE_W-1:0] rate,
    input  logic              line_done,
    input  logic              frame_done,
    output logic              df
);
    logic [RATE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            df  <= 1'b0;
            cnt <= '0;
        end else if (line_done) begin
            if (mode) begin
                if (cnt == rate) begin
                    cnt <= '0;
                    df  <= ~df;
                end else begin
                    cnt <= cnt + RATE_W'(1);
                end
            end else if (frame_done) begin
                df <= ~df;
            end
        end
    end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DATA_W = 16,
    parameter int PIX_W  = 10,
    parameter int LINE_W = 10,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_en,
    input  logic              disp_on_cfg,
    input  logic              invert,
    input  logic [1:0]        depth,
    input  logic              split,
    input  logic [PIX_W-1:0]  width_px,
    input  logic [LINE_W-1:0] height_px,
    input  logic              df_mode,
    input  logic [RATE_W-1:0] df_rate,
    input  logic              freeze,
    input  logic [AW-1:0]     win_start,
    input  logic [AW-1:0]     win_end,
    output logic              dma_req,
    output logic [AW-1:0]     dma_addr,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_rdata,
    output logic              frame,
    output logic              line_load,
    output logic              shift_stb,
    output logic              df,
    output logic              disp_on,
    output logic [3:0]        vdat
);
    localparam int NIB   = DATA_W / 4;
    localparam int NIB_W = (NIB > 1) ? $clog2(NIB) : 1;

    scan_state_t       st, nxt;
    logic [NIB_W-1:0]  nib;
    logic [PIX_W-1:0]  xfer;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] word_sh;
    logic [PIX_W-1:0]  xfer_last;
    logic [LINE_W-1:0] line_last;
    logic [AW-1:0]     ptr;
    logic              nib_end, xfer_end, line_end;
    logic              got_word, frame_end, ptr_restart;
    logic              df_q;

    lcd_scan_geom #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_geom (
        .depth(depth), .split(split), .width_px(width_px), .height_px(height_px),
        .xfer_last(xfer_last), .line_last(line_last)
    );

    assign nib_end     = (nib == NIB_W'(NIB - 1));
    assign xfer_end    = (xfer == xfer_last);
    assign line_end    = (line == line_last);
    assign got_word    = (st == ST_FETCH) && dma_ack;
    assign frame_end   = (st == ST_LOAD) && line_end;
    assign ptr_restart = (st == ST_IDLE) || frame_end;

    lcd_scan_dma_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .restart(ptr_restart), .step(got_word),
        .win_start(win_start), .win_end(win_end), .ptr(ptr)
    );

    lcd_scan_df #(.RATE_W(RATE_W)) u_df (
        .clk(clk), .rst_n(rst_n), .enable(vid_en), .mode(df_mode), .rate(df_rate),
        .line_done(st == ST_LOAD), .frame_done(frame_end), .df(df_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt = st;
        if (!vid_en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  if (!freeze) nxt = ST_FETCH;
                ST_FETCH: if (dma_ack) nxt = ST_SHIFT;
                ST_SHIFT: if (nib_end) nxt = xfer_end ? ST_LOAD : ST_FETCH;
                ST_LOAD:  nxt = (line_end && freeze) ? ST_HALT : ST_FETCH;
                ST_HALT:  if (!freeze) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // scan position counters and fetched word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib  <= '0;
            xfer <= '0;
            line <= '0;
            word <= '0;
        end else begin
            if (got_word) begin
                word <= dma_rdata;
                nib  <= '0;
            end else if (st == ST_SHIFT) begin
                nib <= nib_end ? '0 : nib + NIB_W'(1);
            end
            if (st == ST_SHIFT && nib_end) begin
                xfer <= xfer_end ? '0 : xfer + PIX_W'(1);
            end
            if (st == ST_LOAD) begin
                line <= line_end ? '0 : line + LINE_W'(1);
            end
            if (st == ST_IDLE || st == ST_HALT) begin
                xfer <= '0;
                line <= '0;
            end
        end
    end

    assign word_sh = word << {nib, 2'b00};

    // outputs
    always_comb begin
        dma_req   = (st == ST_FETCH);
        dma_addr  = dma_req ? ptr : '0;
        shift_stb = (st == ST_SHIFT);
        vdat      = shift_stb ? (word_sh[DATA_W-1 -: 4] ^ {4{invert}}) : 4'd0;
        line_load = (st == ST_LOAD);
        frame     = (st == ST_FETCH || st == ST_SHIFT || st == ST_LOAD) && (line == '0);
        df        = df_q;
        disp_on   = disp_on_cfg;
    end
endmodule

// File: rtl/lcd_scan_ctrl_chk.sv
module lcd_scan_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vid_en,
    input logic          df_mode,
    input logic          dma_req,
    input logic          dma_ack,
    input logic [AW-1:0] dma_addr,
    input logic [AW-1:0] win_start,
    input logic [AW-1:0] win_end,
    input logic          frame,
    input logic          line_load,
    input logic          shift_stb,
    input logic          df,
    input logic [3:0]    vdat
);
    p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_en |=> !dma_req && !shift_stb && !line_load && !frame && !df && vdat == 4'd0);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_ack && vid_en |=> dma_req && $stable(dma_addr));

    p_addr_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && (win_start < win_end) |-> dma_addr >= win_start && dma_addr < win_end);

    p_vdat_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_stb |-> vdat == 4'd0);

    p_load_after_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_load |-> $past(shift_stb));

    p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_load |=> !line_load);

    p_df_frame_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vid_en && !df_mode && !line_load |=> $stable(df));
endmodule

bind lcd_scan_ctrl lcd_scan_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .df_mode(df_mode),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_addr(dma_addr),
    .win_start(win_start), .win_end(win_end), .frame(frame),
    .line_load(line_load), .shift_stb(shift_stb), .df(df), .vdat(vdat)
);

// File: tb/lcd_scan_ctrl_bench.sv
module lcd_scan_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vid_en = 1'b0, disp_on_cfg = 1'b0, invert = 1'b0;
    logic [1:0]  depth = 2'd0;
    logic        split = 1'b0;
    logic [9:0]  width_px = 10'd32, height_px = 10'd4;
    logic        df_mode = 1'b0;
    logic [7:0]  df_rate = 8'd0;
    logic        freeze = 1'b0;
    logic [15:0] win_start = 16'h100, win_end = 16'h200;
    logic        dma_req, dma_ack = 1'b0;
    logic [15:0] dma_addr, dma_rdata = 16'h0;
    logic        frame, line_load, shift_stb, df, disp_on;
    logic [3:0]  vdat;

    always #5 clk = ~clk;

    lcd_scan_ctrl u_lcd_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .disp_on_cfg(disp_on_cfg),
        .invert(invert), .depth(depth), .split(split), .width_px(width_px),
        .height_px(height_px), .df_mode(df_mode), .df_rate(df_rate), .freeze(freeze),
        .win_start(win_start), .win_end(win_end), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_ack(dma_ack), .dma_rdata(dma_rdata), .frame(frame), .line_load(line_load),
        .shift_stb(shift_stb), .df(df), .disp_on(disp_on), .vdat(vdat)
    );

    int total = 0, bad = 0;
    int exp_ptr = 0, nib = 0, line_nibs = 0, line_in_frame = 0, frames_done = 0;
    int err_addr = 0, err_data = 0, err_len = 0, err_frame = 0;
    int df_toggles = 0, shifts_total = 0, reqs_total = 0, lines_total = 0;
    int mem_wait = 0, wait_cnt = 0, exp_xfers = 8, exp_lines = 4;
    logic        df_prev = 1'b0;
    logic [15:0] exp_word = 16'h0, exp_sh;
    logic [3:0]  exp_n;
    bit          mon_on = 1'b0;

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model and independent scan monitor
    always @(negedge clk) begin
        if (dma_ack) begin
            dma_ack = 1'b0;
        end else if (dma_req) begin
            if (wait_cnt < mem_wait) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                if (mon_on && dma_addr != exp_ptr[15:0]) err_addr++;
                dma_rdata = mem_word(dma_addr);
                dma_ack   = 1'b1;
                exp_word  = mem_word(exp_ptr[15:0]);
                nib = 0;
                exp_ptr++;
                if (exp_ptr[15:0] == win_end) exp_ptr = int'(win_start);
                reqs_total++;
            end
        end
        if (shift_stb) begin
            exp_sh = exp_word << (4 * nib);
            exp_n  = exp_sh[15:12] ^ {4{invert}};
            if (mon_on && vdat != exp_n) err_data++;
            nib++;
            line_nibs++;
            shifts_total++;
        end
        if (mon_on && (dma_req || shift_stb || line_load)) begin
            if (frame != (line_in_frame == 0)) err_frame++;
        end
        if (line_load) begin
            if (mon_on && line_nibs != exp_xfers * 4) err_len++;
            line_nibs = 0;
            lines_total++;
            line_in_frame++;
            if (line_in_frame == exp_lines) begin
                line_in_frame = 0;
                frames_done++;
                exp_ptr = int'(win_start);
            end
        end
        if (df !== df_prev) begin
            df_toggles++;
            df_prev = df;
        end
    end

    task automatic configure(input logic [1:0] d, input logic sp, input int w, input int h,
                             input logic inv, input logic dm, input int rate,
                             input int ws, input int we, input int wt);
        @(negedge clk);
        vid_en = 1'b0;
        freeze = 1'b0;
        repeat (2) @(negedge clk);
        depth = d; split = sp; width_px = w[9:0]; height_px = h[9:0];
        invert = inv; df_mode = dm; df_rate = rate[7:0];
        win_start = ws[15:0]; win_end = we[15:0];
        mem_wait = wt;
        repeat (2) @(negedge clk);
        #1;
        exp_xfers = (d == 2'd3 && !sp) ? (w / 8) * 3 : w / 4;
        exp_lines = sp ? h / 2 : h;
        exp_ptr = ws; nib = 0; line_nibs = 0; line_in_frame = 0; frames_done = 0;
        err_addr = 0; err_data = 0; err_len = 0; err_frame = 0; wait_cnt = 0;
        df_toggles = 0; df_prev = df; shifts_total = 0; reqs_total = 0; lines_total = 0;
        mon_on = 1'b1;
        vid_en = 1'b1;
    endtask

    task automatic wait_frames(input int n);
        for (int g = 0; g < 40000 && frames_done < n; g++) @(negedge clk);
        check("frame progress", frames_done >= n ? 1 : 0, 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle outputs", {dma_req, shift_stb, line_load, frame, df, vdat}, 0);
    endtask

    task automatic t_mono;
        configure(2'd0, 1'b0, 32, 4, 1'b0, 1'b0, 0, 'h100, 'h200, 0);
        wait_frames(2);
        check("R3 mono line length", err_len, 0);
        check("R4 mono lines", lines_total, 8);
        check("R5 frame marker", err_frame, 0);
        check("R6 nibble order", err_data, 0);
        check("R8 address sequence", err_addr, 0);
    endtask

    task automatic t_color_single;
        configure(2'd3, 1'b0, 16, 3, 1'b0, 1'b0, 0, 'h300, 'h400, 0);
        wait_frames(2);
        check("R3 colour words", shifts_total, 2 * 3 * 6 * 4);
        check("R3 colour line length", err_len, 0);
        check("R6 colour data", err_data, 0);
    endtask

    task automatic t_color_split;
        configure(2'd3, 1'b1, 16, 6, 1'b0, 1'b0, 0, 'h20, 'h80, 0);
        wait_frames(2);
        check("R3 split colour length", err_len, 0);
        check("R4 split lines", lines_total, 6);
        check("R5 split frame marker", err_frame, 0);
    endtask

    task automatic t_grey_wait;
        configure(2'd1, 1'b1, 24, 4, 1'b0, 1'b0, 0, 'h500, 'h600, 2);
        wait_frames(2);
        check("R3 grey split length", err_len, 0);
        check("R4 grey split lines", lines_total, 4);
        check("R8 wait-state addresses", err_addr, 0);
    endtask

    task automatic t_invert;
        configure(2'd0, 1'b0, 32, 2, 1'b1, 1'b0, 0, 'h10, 'h90, 0);
        wait_frames(1);
        check("R7 inverted data", err_data, 0);
    endtask

    task automatic t_wrap;
        configure(2'd0, 1'b0, 32, 3, 1'b0, 1'b0, 0, 'h40, 'h45, 0);
        wait_frames(2);
        check("R8 wrap addresses", err_addr, 0);
        check("R8 request count", reqs_total, 48);
    endtask

    task automatic t_df_frame;
        configure(2'd0, 1'b0, 8, 2, 1'b0, 1'b0, 0, 'h0, 'h10, 0);
        wait_frames(3);
        repeat (3) @(negedge clk);
        check("R9 df per frame", df_toggles, 3);
    endtask

    task automatic t_df_lines;
        configure(2'd0, 1'b0, 8, 6, 1'b0, 1'b1, 2, 'h0, 'h10, 0);
        wait_frames(2);
        repeat (3) @(negedge clk);
        check("R10 df every 3 lines", df_toggles, 4);
        configure(2'd0, 1'b0, 8, 3, 1'b0, 1'b1, 0, 'h0, 'h10, 0);
        wait_frames(2);
        repeat (3) @(negedge clk);
        check("R10 df every line", df_toggles, 6);
    endtask

    task automatic t_freeze;
        int s_snap, r_snap;
        configure(2'd0, 1'b0, 16, 4, 1'b0, 1'b0, 0, 'h200, 'h300, 0);
        wait_frames(1);
        for (int g = 0; g < 5000 && line_in_frame != 2; g++) @(negedge clk);
        freeze = 1'b1;
        wait_frames(2);
        repeat (3) @(negedge clk);
        s_snap = shifts_total;
        r_snap = reqs_total;
        repeat (30) @(negedge clk);
        check("R11 frame completed", lines_total, 8);
        check("R11 no strobes frozen", shifts_total, s_snap);
        check("R11 no requests frozen", reqs_total, r_snap);
        freeze = 1'b0;
        wait_frames(3);
        check("R11 restart address", err_addr, 0);
        check("R11 restart line length", err_len, 0);
        check("R11 restart frame marker", err_frame, 0);
    endtask

    task automatic t_disable;
        int r_snap;
        configure(2'd0, 1'b0, 8, 2, 1'b0, 1'b0, 0, 'h0, 'h10, 0);
        disp_on_cfg = 1'b0;
        wait_frames(1);
        repeat (4) @(negedge clk);
        check("R2 disp_on off while running", disp_on, 0);
        check("R9 df set after a frame", df, 1);
        vid_en = 1'b0;
        disp_on_cfg = 1'b1;
        @(negedge clk);
        check("R2 outputs low when disabled",
              {dma_req, shift_stb, line_load, frame, df, vdat}, 0);
        check("R2 disp_on independent", disp_on, 1);
        r_snap = reqs_total;
        repeat (10) @(negedge clk);
        check("R2 no requests disabled", reqs_total, r_snap);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mono();
        t_color_single();
        t_color_split();
        t_grey_wait();
        t_invert();
        t_wrap();
        t_df_frame();
        t_df_lines();
        t_freeze();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule